// File: doc/BRIEF.md
# Vertical display and sync generator

This block sits beside the row and scanline counters of a character-based CRT controller and produces the vertical timing terms: a vertical sync pulse, the vertical display-enable term and a small frame counter. The counters are external; the block sees their live values together with a character-clock enable and a strobe that marks the first character of each scanline. Every decision is made on a character-clock enable, so a register write that happens to equal the live row count is acted on at the next character clock, even in the middle of a scanline or a row.

The sync position register starts a pulse whenever it matches the row count, but a row can start at most one pulse. A pulse is timed by a 4-bit scanline counter, and a new match on the scanline where a pulse ends joins the two pulses without a gap. Display enable is raised at the origin of each frame and dropped when the displayed-rows register matches the row count. The first scanline of a frame is exempt, so at least one scanline is always shown. The frame counter advances on each fall of display enable. Its bit 0 selects the interlace field and its bits 3 and 4 serve as slow and slower cursor blink phases.

Top module: `vert_timing_gen`

## Requirements
- R1: When `char_en_i` is high and `vs_pos_i` equals `row_i`, `vsync_o` is high after that clock edge, whatever the character position within the scanline, provided no pulse has already been started in the current row.
- R2: A pulse ends at the 16th scanline-start strobe after the one in which it began, so a pulse started on a scanline start covers exactly 16 scanlines.
- R3: A row starts at most one pulse: after a pulse ends inside a row whose number still equals `vs_pos_i`, `vsync_o` stays low until a later row. A new row is a scanline start with `line_i` equal to 0.
- R4: If the start condition holds on the scanline start where a pulse would end, `vsync_o` stays high with no gap and the pulse lasts a further 16 scanlines.
- R5: When `char_en_i` is high and `vdisp_i` equals `row_i`, `vde_o` is low after that edge, even mid-scanline, except during the scanline where `row_i` and `line_i` are both 0.
- R6: With `vdisp_i` equal to 0, exactly one scanline (row 0, scanline 0) is displayed per frame.
- R7: A scanline-start strobe with `row_i` and `line_i` both 0 sets `vde_o` high after that edge.
- R8: `frame_o` increments by one each time `vde_o` falls and at no other time; if `vdisp_i` never matches a row, it does not change.
- R9: `frame_o` is 5 bits and wraps from 31 to 0; bit 0 is the interlace field and alternates every frame.
- R10: After reset `vsync_o` is 0, `vde_o` is 1 and `frame_o` is 0.
- R11: While `char_en_i` is low no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_en_i | input | 1 | Character clock enable |
| line_start_i | input | 1 | First character of a scanline (qualified by `char_en_i`) |
| row_i | input | ROW_W | Live character row count |
| line_i | input | LINE_W | Live scanline count within the row |
| vdisp_i | input | ROW_W | Number of displayed rows |
| vs_pos_i | input | ROW_W | Row at which vertical sync starts |
| vsync_o | output | 1 | Vertical sync pulse |
| vde_o | output | 1 | Vertical display enable |
| frame_o | output | FRM_W | Frame counter (bit 0 field, bits 3/4 blink phases) |

## Verification
The assertions check on every cycle that a pulse only begins when the sync position matched the row, that the width counter moves only on scanline starts and a pulse only ends from a full count, that display enable obeys its set and clear conditions one enabled clock later, and that the frame counter moves in step with each display-enable fall. Only the bench scenarios can show the once-per-row guard, the gapless joining of two pulses, the one-scanline minimum display and the counter wrap. Each of these needs a sequence of rows, or a register write at a chosen character, to appear. A sweep over every sync position and displayed-row count in a small frame compares every enabled clock against expected values computed by arithmetic.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // per-clock qualifiers seen by the sync generator
  typedef struct packed {
    logic en;
    logic line_start;
    logic new_row;
  } vs_tick_t;

  // per-clock qualifiers seen by the display-enable generator
  typedef struct packed {
    logic en;
    logic frame_top;
    logic first_line;
  } de_tick_t;

  localparam int unsigned FieldBit = 0;

endpackage

// File: rtl/vtg_vsync.sv
module vtg_vsync
  import vtg_pkg::*;
#(
  parameter int unsigned ROW_W = 7,
  parameter int unsigned VS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vs_tick_t         tk_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] vs_pos_i,
  output logic             vsync_o
);

  localparam logic [VS_W-1:0] CntLast = {VS_W{1'b1}};

  logic            active_q, armed_q;
  logic [VS_W-1:0] cnt_q;
  logic            armed_now, hit, last, fire;

  assign armed_now = armed_q | tk_i.new_row;
  assign hit       = tk_i.en & armed_now & (vs_pos_i == row_i);
  assign last      = tk_i.en & tk_i.line_start & active_q & (cnt_q == CntLast);
  // a start is taken when idle or on the very scanline the pulse ends
  assign fire      = hit & (~active_q | last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      armed_q  <= 1'b1;
      cnt_q    <= '0;
    end else if (tk_i.en) begin
      armed_q <= armed_now & ~fire;
      if (active_q && tk_i.line_start) cnt_q <= cnt_q + 1'b1;
      if (active_q) active_q <= ~last | fire;
      else          active_q <= fire;
    end
  end

  assign vsync_o = active_q;

  AST_VS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> $past(vs_pos_i == row_i && tk_i.en)); // R1

  AST_VS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !(tk_i.en && tk_i.line_start) |=> active_q && $stable(cnt_q)); // R2

  AST_VS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_o) |-> $past(cnt_q) == CntLast); // R2

  AST_VS_IDLE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> cnt_q == '0); // R2

endmodule

// File: rtl/vtg_vde.sv
module vtg_vde
  import vtg_pkg::*;
#(
  parameter int unsigned ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  de_tick_t         tk_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] vdisp_i,
  output logic             vde_o,
  output logic             fall_o
);

  logic de_q, clr;

  // the origin scanline cannot be blanked, so vdisp 0 still shows one line
  assign clr    = tk_i.en & (vdisp_i == row_i) & ~tk_i.first_line;
  assign fall_o = de_q & clr & ~tk_i.frame_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             de_q <= 1'b1;
    else if (tk_i.frame_top) de_q <= 1'b1;
    else if (clr)            de_q <= 1'b0;
  end

  assign vde_o = de_q;

  AST_DE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_i.frame_top |=> vde_o); // R7

  AST_DE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tk_i.en && (vdisp_i == row_i) && !tk_i.first_line |=> !vde_o); // R5

endmodule

// File: rtl/vtg_frame.sv
module vtg_frame #(
  parameter int unsigned FRM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [FRM_W-1:0] frame_o
);

  logic [FRM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign frame_o = cnt_q;

endmodule

// File: rtl/vert_timing_gen.sv
module vert_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned LINE_W = 5,
  parameter int unsigned VS_W   = 4,
  parameter int unsigned FRM_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_en_i,
  input  logic              line_start_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ROW_W-1:0]  vdisp_i,
  input  logic [ROW_W-1:0]  vs_pos_i,
  output logic              vsync_o,
  output logic              vde_o,
  output logic [FRM_W-1:0]  frame_o
);

  vs_tick_t vs_tk;
  de_tick_t de_tk;
  logic     origin, ls_en, de_fall;

  assign origin = (row_i == '0) & (line_i == '0);
  assign ls_en  = char_en_i & line_start_i;

  assign vs_tk.en         = char_en_i;
  assign vs_tk.line_start = line_start_i;
  assign vs_tk.new_row    = ls_en & (line_i == '0);

  assign de_tk.en         = char_en_i;
  assign de_tk.frame_top  = ls_en & origin;
  assign de_tk.first_line = origin;

  vtg_vsync #(.ROW_W(ROW_W), .VS_W(VS_W)) i_vsync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tk_i     (vs_tk),
    .row_i    (row_i),
    .vs_pos_i (vs_pos_i),
    .vsync_o  (vsync_o)
  );

  vtg_vde #(.ROW_W(ROW_W)) i_vde (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tk_i    (de_tk),
    .row_i   (row_i),
    .vdisp_i (vdisp_i),
    .vde_o   (vde_o),
    .fall_o  (de_fall)
  );

  vtg_frame #(.FRM_W(FRM_W)) i_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (de_fall),
    .frame_o (frame_o)
  );

  AST_FRM_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vde_o) |-> frame_o == FRM_W'($past(frame_o) + 1'b1)); // R8

  AST_FRM_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(vde_o) |-> $stable(frame_o)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_en_i |=> $stable(vsync_o) && $stable(vde_o)); // R11

endmodule

// File: tb/test_vert_timing_gen.sv
module test_vert_timing_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       char_en, line_start;
  logic [6:0] row, vdisp, vs_pos;
  logic [4:0] line;
  logic       vsync, vde;
  logic [4:0] frame;
  int         n_chk = 0;
  int         n_err = 0;

  always #5 clk = ~clk;

  vert_timing_gen i_vert_timing_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .char_en_i    (char_en),
    .line_start_i (line_start),
    .row_i        (row),
    .line_i       (line),
    .vdisp_i      (vdisp),
    .vs_pos_i     (vs_pos),
    .vsync_o      (vsync),
    .vde_o        (vde),
    .frame_o      (frame)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; char_en = 1'b0; line_start = 1'b0; row = '0; line = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one enabled character clock followed by one idle clock; outputs sampled after return
  task automatic step(input int r, input int l, input int c);
    @(negedge clk);
    row = 7'(r); line = 5'(l); line_start = (c == 0); char_en = 1'b1;
    @(negedge clk);
    char_en = 1'b0; line_start = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    int g, exp_vs, exp_de, lim;
    vdisp = 7'd100; vs_pos = 7'd127;

    // R10 reset state
    do_reset();
    chk("R10 vsync", vsync, 0);
    chk("R10 vde", vde, 1);
    chk("R10 frame", frame, 0);

    // sweep: 8 rows x 4 lines x 3 chars, every sync position and displayed count
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v <= 8; v++) begin
        vs_pos = 7'(p); vdisp = 7'(v);
        do_reset();
        lim = (v == 0) ? 1 : 4 * v;
        for (int f = 0; f < 2; f++) begin
          for (int r = 0; r < 8; r++)
            for (int l = 0; l < 4; l++)
              for (int c = 0; c < 3; c++) begin
                step(r, l, c);
                g = f * 32 + r * 4 + l;
                exp_vs = (g >= 4 * p && ((g - 4 * p) % 32) < 16) ? 1 : 0;
                chk("R1/R2 sweep vsync", vsync, exp_vs);
                exp_de = ((r * 4 + l) < lim) ? 1 : 0;
                chk("R5/R6/R7 sweep vde", vde, exp_de);
              end
          chk("R8 sweep frame", frame, (v < 8) ? f + 1 : 0);
        end
      end
    end

    // R3: 20-line rows, pulse ends inside the matching row and must not restart
    vs_pos = 7'd1; vdisp = 7'd100;
    do_reset();
    for (int r = 0; r < 3; r++)
      for (int l = 0; l < 20; l++)
        for (int c = 0; c < 2; c++) begin
          step(r, l, c);
          exp_vs = (r == 1 && l < 16) ? 1 : 0;
          chk("R3 once per row", vsync, exp_vs);
        end

    // R1 mid-scanline start, R2 end counted from the start scanline
    vs_pos = 7'd127;
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 20; l++)
        for (int c = 0; c < 4; c++) begin
          if (r == 2 && l == 5 && c == 2) vs_pos = 7'd2;
          step(r, l, c);
          g = r * 20 + l;
          exp_vs = ((g > 45 || (g == 45 && c >= 2)) && g < 61) ? 1 : 0;
          chk("R1/R2 mid-line start", vsync, exp_vs);
        end

    // R4: retarget to row 5 while pulse from row 1 runs; ends on row 5 start
    vs_pos = 7'd1;
    do_reset();
    for (int r = 0; r < 12; r++)
      for (int l = 0; l < 4; l++)
        for (int c = 0; c < 2; c++) begin
          if (r == 2) vs_pos = 7'd5;
          step(r, l, c);
          g = r * 4 + l;
          exp_vs = (g >= 4 && g <= 35) ? 1 : 0;
          chk("R4 gapless join", vsync, exp_vs);
        end

    // R6: vdisp written 0 mid first scanline, one scanline stays displayed
    vs_pos = 7'd127; vdisp = 7'd100;
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 4; c++) begin
          if (r == 0 && l == 0 && c == 2) vdisp = 7'd0;
          step(r, l, c);
          chk("R6 single line", vde, (r == 0 && l == 0) ? 1 : 0);
        end

    // R5: vdisp written equal to live row mid-scanline
    vdisp = 7'd100;
    do_reset();
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 4; c++) begin
          if (r == 2 && l == 1 && c == 2) vdisp = 7'd2;
          step(r, l, c);
          exp_de = (r < 2 || (r == 2 && l == 0) || (r == 2 && c < 2)) ? 1 : 0;
          chk("R5 mid-line clear", vde, exp_de);
        end
    chk("R8 one fall", frame, 1);

    // R9: wrap and field bit over 34 tiny frames
    vdisp = 7'd1;
    do_reset();
    for (int f = 0; f < 34; f++) begin
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < 2; c++) step(r, 0, c);
      chk("R9 wrap", frame, (f + 1) % 32);
      chk("R9 field", frame[0], (f + 1) % 2);
    end

    // R11: enable low, matching inputs held, nothing moves
    vs_pos = 7'd0; vdisp = 7'd0;
    do_reset();
    @(negedge clk);
    row = 7'd0; line = 5'd1; line_start = 1'b1; char_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 vsync held", vsync, 0);
    chk("R11 vde held", vde, 1);
    chk("R11 frame held", frame, 0);
    step(0, 1, 0);
    chk("R11 R1 vsync after enable", vsync, 1);
    chk("R11 R5 vde after enable", vde, 0);
    chk("R11 R8 frame after enable", frame, 1);

    report();
  end

endmodule